// File: doc/BRIEF.md
# Serial-to-Parallel Bus Write Sequencer

This block sits between a serial management slave front end and a narrow parallel peripheral bus. The front end delivers a command byte and a data byte together, flagged by a one-cycle pair-valid strobe. The sequencer then runs exactly one timed write on the parallel side. It drives the address nibble and the data bus, pulls a chip select low, waits out an address setup interval and pulses an active-low write strobe. It also produces a second chip select for a character display controller. That select trails the write strobe by a fixed lag and is released together with it.

Every phase is counted in clock cycles. At the intended 50 MHz clock, the defaults give 100 ns of setup, 20 ns of hold, a 40 ns display-select lag and 1000 ns between the starts of successive cycles. A 2-bit width setting chooses the strobe length from four values: 180, 300, 420 or 540 ns. A busy flag covers the whole cycle, including the enforced spacing. One byte pair that arrives while busy is kept and started as soon as the spacing ends.

Top module: `pbus_write_seq`

## Requirements
- R1: After reset, bus_cs_n, bus_wr_n and disp_cs_n are high, busy is low, bus_addr and bus_data are zero, and the width setting holds code 2'b11 (27 cycles).
- R2: While the block is idle, a pair_valid seen at a clock edge starts a cycle. bus_cs_n goes low and busy goes high after that same edge. No bus activity ever starts without a pair_valid.
- R3: bus_addr takes bits [3:0] of the command byte. Bit 0 is the display read/not-write line and bit 1 is the data/control line, both passed through unchanged. bus_data takes the data byte.
- R4: bus_wr_n falls SETUP_CYC (5) cycles after bus_cs_n falls.
- R5: bus_wr_n stays low for WIDTH_BASE + WIDTH_STEP*code cycles. Codes 2'b00, 2'b01, 2'b10 and 2'b11 give 9, 15, 21 and 27 cycles. The code is written through width_we/width_code and is read when the strobe begins, so a write during a strobe affects only later cycles.
- R6: disp_cs_n falls LAG_CYC (2) cycles after bus_wr_n falls and rises in the same cycle as bus_wr_n. Its low time is therefore LAG_CYC cycles shorter than the strobe.
- R7: bus_cs_n rises HOLD_CYC (1) cycle after bus_wr_n rises. bus_addr and bus_data stay constant while bus_cs_n is low and keep their values until the next cycle starts.
- R8: busy stays high for exactly SPACING_CYC (50) cycles per write. Successive falling edges of disp_cs_n are at least SPACING_CYC cycles apart.
- R9: A pair_valid that arrives while busy is held as one pending request. That request starts in the first cycle after the spacing ends, so busy does not drop. Further pair_valid strobes while a request is pending are dropped.
- R10: While busy is low, all three strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_valid | input | 1 | Command and data bytes both received (one-cycle strobe) |
| cmd_byte | input | CMD_W | Command/address byte |
| data_byte | input | DATA_W | Data byte |
| width_we | input | 1 | Load the strobe width setting |
| width_code | input | 2 | New strobe width code |
| bus_addr | output | ADDR_W | Parallel address lines |
| bus_data | output | DATA_W | Parallel data bus |
| bus_cs_n | output | 1 | Peripheral chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| disp_cs_n | output | 1 | Display controller chip select, active low |
| busy | output | 1 | Cycle in progress, including spacing |

## Verification
The bench builds the block with its default parameters: 5 setup cycles, 1 hold cycle, a 2-cycle lag, 50-cycle spacing and widths of 9 to 27 cycles. These values let a full 50-cycle window record every edge of a write. They also leave room for all four width codes and for a back-to-back pending start at cycle 50, followed by a dropped third request. Because the spacing is far longer than the longest strobe, the bench can also move the width setting mid-strobe and see the old width kept while the next write uses the new one.

// File: rtl/pbus_seq_pkg.sv
package pbus_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_GAP
   } phase_e;

   // Strobe length in cycles for a 2-bit width code.
   function automatic int unsigned strobe_cycles(input logic [1:0] code,
                                                 input int unsigned base,
                                                 input int unsigned step);
      return base + step * int'(code);
   endfunction

endpackage

// File: rtl/pbus_req_slot.sv
// One-entry holding slot for a byte pair that arrives while the bus is busy.
module pbus_req_slot #(
   parameter int CMD_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [CMD_W-1:0]  push_cmd,
   input  logic [DATA_W-1:0] push_data,
   output logic              slot_valid,
   output logic [CMD_W-1:0]  slot_cmd,
   output logic [DATA_W-1:0] slot_data
);

   logic              vld_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         cmd_q  <= '0;
         data_q <= '0;
      end else if (pop) begin
         vld_q <= push;
         if (push) begin
            cmd_q  <= push_cmd;
            data_q <= push_data;
         end
      end else if (push && !vld_q) begin
         vld_q  <= 1'b1;
         cmd_q  <= push_cmd;
         data_q <= push_data;
      end
   end

   assign slot_valid = vld_q;
   assign slot_cmd   = cmd_q;
   assign slot_data  = data_q;

endmodule

// File: rtl/pbus_phase_fsm.sv
// Phase sequencer: setup, strobe, hold, then spacing until the next start.
module pbus_phase_fsm
   import pbus_seq_pkg::*;
#(
   parameter int CMD_W       = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SETUP_CYC   = 5,
   parameter int HOLD_CYC    = 1,
   parameter int SPACING_CYC = 50,
   parameter int WIDTH_BASE  = 9,
   parameter int WIDTH_STEP  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  start_cmd,
   input  logic [DATA_W-1:0] start_data,
   input  logic [1:0]        width_code,
   output logic              ready,
   output logic              busy,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_cs_n,
   output logic              bus_wr_n,
   output logic              wr_n_nxt
);

   localparam int CNT_W = $clog2(SPACING_CYC + 1);

   phase_e            ph_q, ph_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [CNT_W-1:0]  span_q, span_d;
   logic              cs_q, cs_d;
   logic              wr_q, wr_d;
   logic              busy_q, busy_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] data_q, data_d;
   logic              span_done;

   assign span_done = (span_q == CNT_W'(SPACING_CYC - 1));
   assign ready     = (ph_q == PH_IDLE) || ((ph_q == PH_GAP) && span_done);

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_q;
      span_d = busy_q ? span_q + 1'b1 : span_q;
      cs_d   = cs_q;
      wr_d   = wr_q;
      busy_d = busy_q;
      addr_d = addr_q;
      data_d = data_q;
      case (ph_q)
         PH_SETUP: begin
            if (cnt_q == '0) begin
               wr_d  = 1'b0;
               ph_d  = PH_STROBE;
               cnt_d = CNT_W'(strobe_cycles(width_code, WIDTH_BASE, WIDTH_STEP) - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_STROBE: begin
            if (cnt_q == '0) begin
               wr_d  = 1'b1;
               ph_d  = PH_HOLD;
               cnt_d = CNT_W'(HOLD_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_HOLD: begin
            if (cnt_q == '0) begin
               cs_d = 1'b1;
               ph_d = PH_GAP;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_GAP: begin
            if (span_done) begin
               busy_d = 1'b0;
               ph_d   = PH_IDLE;
            end
         end
         default: ;
      endcase
      if (start) begin
         ph_d   = PH_SETUP;
         cnt_d  = CNT_W'(SETUP_CYC - 1);
         span_d = '0;
         cs_d   = 1'b0;
         busy_d = 1'b1;
         addr_d = start_cmd[ADDR_W-1:0];
         data_d = start_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         span_q <= '0;
         cs_q   <= 1'b1;
         wr_q   <= 1'b1;
         busy_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         span_q <= span_d;
         cs_q   <= cs_d;
         wr_q   <= wr_d;
         busy_q <= busy_d;
         addr_q <= addr_d;
         data_q <= data_d;
      end
   end

   assign busy     = busy_q;
   assign bus_addr = addr_q;
   assign bus_data = data_q;
   assign bus_cs_n = cs_q;
   assign bus_wr_n = wr_q;
   assign wr_n_nxt = wr_d;

endmodule

// File: rtl/pbus_disp_cs.sv
// Display chip select: OR of the write strobe and its LAG-cycle delayed copy, registered.
module pbus_disp_cs #(
   parameter int LAG_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n_nxt,
   output logic disp_cs_n
);

   logic [LAG_CYC-1:0] dly_q;
   logic               dcs_q;

   generate
      if (LAG_CYC == 1) begin : g_lag_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly_q <= '1;
            else        dly_q <= wr_n_nxt;
         end
      end else begin : g_lag_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly_q <= '1;
            else        dly_q <= {dly_q[LAG_CYC-2:0], wr_n_nxt};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dcs_q <= 1'b1;
      else        dcs_q <= wr_n_nxt | dly_q[LAG_CYC-1];
   end

   assign disp_cs_n = dcs_q;

endmodule

// File: rtl/pbus_write_seq.sv
module pbus_write_seq #(
   parameter int         CMD_W       = 8,
   parameter int         DATA_W      = 8,
   parameter int         ADDR_W      = 4,
   parameter int         SETUP_CYC   = 5,
   parameter int         HOLD_CYC    = 1,
   parameter int         LAG_CYC     = 2,
   parameter int         SPACING_CYC = 50,
   parameter int         WIDTH_BASE  = 9,
   parameter int         WIDTH_STEP  = 6,
   parameter logic [1:0] WIDTH_RESET = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_valid,
   input  logic [CMD_W-1:0]  cmd_byte,
   input  logic [DATA_W-1:0] data_byte,
   input  logic              width_we,
   input  logic [1:0]        width_code,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_cs_n,
   output logic              bus_wr_n,
   output logic              disp_cs_n,
   output logic              busy
);

   localparam int WIDTH_MAX = WIDTH_BASE + 3 * WIDTH_STEP;
   localparam int CYCLE_LEN = SETUP_CYC + WIDTH_MAX + HOLD_CYC;

   generate
      if (SETUP_CYC < 1 || HOLD_CYC < 1 || LAG_CYC < 1) begin : g_bad_phase
         $error("pbus_write_seq: setup, hold and lag must each be at least one cycle");
      end
      if (LAG_CYC >= WIDTH_BASE) begin : g_bad_lag
         $error("pbus_write_seq: display select lag must be shorter than the shortest strobe");
      end
      if (CYCLE_LEN >= SPACING_CYC) begin : g_bad_spacing
         $error("pbus_write_seq: spacing must exceed setup plus longest strobe plus hold");
      end
      if (ADDR_W > CMD_W || ADDR_W < 2) begin : g_bad_addr
         $error("pbus_write_seq: address width must be between 2 and the command width");
      end
   endgenerate

   logic [1:0]        wsel_q;
   logic              ready, start, direct, push, pop;
   logic              slot_valid;
   logic [CMD_W-1:0]  slot_cmd, sel_cmd;
   logic [DATA_W-1:0] slot_data, sel_data;
   logic              wr_n_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wsel_q <= WIDTH_RESET;
      else if (width_we) wsel_q <= width_code;
   end

   assign start    = ready && (slot_valid || pair_valid);
   assign direct   = start && !slot_valid;
   assign pop      = start && slot_valid;
   assign push     = pair_valid && !direct;
   assign sel_cmd  = slot_valid ? slot_cmd  : cmd_byte;
   assign sel_data = slot_valid ? slot_data : data_byte;

   pbus_req_slot #(
      .CMD_W (CMD_W),
      .DATA_W(DATA_W)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_cmd  (cmd_byte),
      .push_data (data_byte),
      .slot_valid(slot_valid),
      .slot_cmd  (slot_cmd),
      .slot_data (slot_data)
   );

   pbus_phase_fsm #(
      .CMD_W      (CMD_W),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .SETUP_CYC  (SETUP_CYC),
      .HOLD_CYC   (HOLD_CYC),
      .SPACING_CYC(SPACING_CYC),
      .WIDTH_BASE (WIDTH_BASE),
      .WIDTH_STEP (WIDTH_STEP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_cmd (sel_cmd),
      .start_data(sel_data),
      .width_code(wsel_q),
      .ready     (ready),
      .busy      (busy),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .bus_cs_n  (bus_cs_n),
      .bus_wr_n  (bus_wr_n),
      .wr_n_nxt  (wr_n_nxt)
   );

   pbus_disp_cs #(
      .LAG_CYC(LAG_CYC)
   ) u_disp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_n_nxt (wr_n_nxt),
      .disp_cs_n(disp_cs_n)
   );

endmodule

// File: rtl/pbus_write_seq_chk.sv
module pbus_write_seq_chk #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SETUP_CYC   = 5,
   parameter int HOLD_CYC    = 1,
   parameter int LAG_CYC     = 2,
   parameter int SPACING_CYC = 50,
   parameter int WIDTH_BASE  = 9,
   parameter int WIDTH_STEP  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_cs_n,
   input logic              bus_wr_n,
   input logic              disp_cs_n,
   input logic              busy
);

   logic [15:0] cs_age, wr_age, wr_hi_age, gap_age;
   logic        dcs_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_age    <= '0;
         wr_age    <= '0;
         wr_hi_age <= '0;
         gap_age   <= '0;
         dcs_seen  <= 1'b0;
      end else begin
         cs_age    <= bus_cs_n ? 16'd0 : ((cs_age == 16'hFFFF) ? cs_age : cs_age + 16'd1);
         wr_age    <= bus_wr_n ? 16'd0 : ((wr_age == 16'hFFFF) ? wr_age : wr_age + 16'd1);
         wr_hi_age <= !bus_wr_n ? 16'd0 : ((wr_hi_age == 16'hFFFF) ? wr_hi_age : wr_hi_age + 16'd1);
         if ($fell(disp_cs_n)) begin
            gap_age  <= 16'd1;
            dcs_seen <= 1'b1;
         end else if (gap_age != 16'hFFFF) begin
            gap_age <= gap_age + 16'd1;
         end
      end
   end

   a_r4_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wr_n) |-> (cs_age == 16'(SETUP_CYC)));

   a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> ((wr_age == 16'(WIDTH_BASE)) ||
                           (wr_age == 16'(WIDTH_BASE + WIDTH_STEP)) ||
                           (wr_age == 16'(WIDTH_BASE + 2 * WIDTH_STEP)) ||
                           (wr_age == 16'(WIDTH_BASE + 3 * WIDTH_STEP))));

   a_r6_disp_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disp_cs_n) |-> (wr_age == 16'(LAG_CYC)));

   a_r6_disp_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> $rose(disp_cs_n));

   a_r6_disp_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_cs_n |-> !bus_wr_n);

   a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> (wr_hi_age == 16'(HOLD_CYC)));

   a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

   a_r8_disp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(disp_cs_n) && dcs_seen) |-> (gap_age >= 16'(SPACING_CYC)));

   a_r10_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_cs_n && bus_wr_n && disp_cs_n));

endmodule

bind pbus_write_seq pbus_write_seq_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .SETUP_CYC  (SETUP_CYC),
   .HOLD_CYC   (HOLD_CYC),
   .LAG_CYC    (LAG_CYC),
   .SPACING_CYC(SPACING_CYC),
   .WIDTH_BASE (WIDTH_BASE),
   .WIDTH_STEP (WIDTH_STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_data (bus_data),
   .bus_cs_n (bus_cs_n),
   .bus_wr_n (bus_wr_n),
   .disp_cs_n(disp_cs_n),
   .busy     (busy)
);

// File: tb/pbus_write_seq_tb.sv
`timescale 1ns/1ps
module pbus_write_seq_tb;

   localparam int SETUP = 5;
   localparam int HOLD  = 1;
   localparam int LAG   = 2;
   localparam int SPAN  = 50;
   localparam int NCAP  = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pair_valid = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic [7:0] data_byte = '0;
   logic       width_we = 1'b0;
   logic [1:0] width_code = '0;
   logic [3:0] bus_addr;
   logic [7:0] bus_data;
   logic       bus_cs_n, bus_wr_n, disp_cs_n, busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic       cs_a  [NCAP];
   logic       wr_a  [NCAP];
   logic       dcs_a [NCAP];
   logic       bsy_a [NCAP];
   logic [3:0] ad_a  [NCAP];
   logic [7:0] dt_a  [NCAP];

   always #2 clk = ~clk;

   pbus_write_seq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_valid(pair_valid),
      .cmd_byte  (cmd_byte),
      .data_byte (data_byte),
      .width_we  (width_we),
      .width_code(width_code),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .bus_cs_n  (bus_cs_n),
      .bus_wr_n  (bus_wr_n),
      .disp_cs_n (disp_cs_n),
      .busy      (busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_width(input logic [1:0] code);
      @(negedge clk);
      width_we = 1'b1; width_code = code;
      @(negedge clk);
      width_we = 1'b0;
   endtask

   // Pulse pair_valid; on return the edge that saw it has passed (sample index 0).
   task automatic launch(input logic [7:0] c, input logic [7:0] d);
      @(negedge clk);
      pair_valid = 1'b1; cmd_byte = c; data_byte = d;
      @(negedge clk);
      pair_valid = 1'b0;
   endtask

   // Records n samples; optional injections of pair_valid (ia, ib) and a width write (wk).
   task automatic capture(input int n,
                          input int ia, input logic [7:0] ca, input logic [7:0] da,
                          input int ib, input logic [7:0] cb, input logic [7:0] db,
                          input int wk, input logic [1:0] wc);
      for (int k = 0; k < n; k++) begin
         cs_a[k] = bus_cs_n; wr_a[k] = bus_wr_n; dcs_a[k] = disp_cs_n;
         bsy_a[k] = busy; ad_a[k] = bus_addr; dt_a[k] = bus_data;
         pair_valid = (k == ia) || (k == ib);
         if (k == ia) begin cmd_byte = ca; data_byte = da; end
         if (k == ib) begin cmd_byte = cb; data_byte = db; end
         width_we = (k == wk);
         width_code = wc;
         @(negedge clk);
      end
      pair_valid = 1'b0;
      width_we = 1'b0;
   endtask

   // Checks one write whose chip select fell at sample k0.
   task automatic check_cycle(input int k0, input int w, input logic [3:0] ea,
                              input logic [7:0] ed, input string tag);
      int wr_lo = 0, dcs_lo = 0, cs_lo = 0, bsy_hi = 0;
      int wr_first = -1, dcs_first = -1, cs_last = -1;
      for (int k = k0; k < k0 + SPAN; k++) begin
         if (!wr_a[k])  begin wr_lo++;  if (wr_first < 0)  wr_first = k - k0;  end
         if (!dcs_a[k]) begin dcs_lo++; if (dcs_first < 0) dcs_first = k - k0; end
         if (!cs_a[k])  begin cs_lo++;  cs_last = k - k0; end
         if (bsy_a[k])  bsy_hi++;
      end
      chk(!cs_a[k0], "R2", {tag, " cs low after start"}, cs_a[k0], 0);
      chk(ad_a[k0 + SETUP] == ea, "R3", {tag, " address"}, ad_a[k0 + SETUP], ea);
      chk(dt_a[k0 + SETUP] == ed, "R3", {tag, " data"}, dt_a[k0 + SETUP], ed);
      chk(wr_first == SETUP, "R4", {tag, " strobe start"}, wr_first, SETUP);
      chk(wr_lo == w, "R5", {tag, " strobe width"}, wr_lo, w);
      chk(dcs_first == SETUP + LAG, "R6", {tag, " display select start"}, dcs_first, SETUP + LAG);
      chk(dcs_lo == w - LAG, "R6", {tag, " display select width"}, dcs_lo, w - LAG);
      chk(cs_last == SETUP + w + HOLD - 1, "R7", {tag, " cs release"}, cs_last, SETUP + w + HOLD - 1);
      chk(cs_lo == SETUP + w + HOLD, "R7", {tag, " cs low length"}, cs_lo, SETUP + w + HOLD);
      chk(bsy_hi == SPAN, "R8", {tag, " busy length"}, bsy_hi, SPAN);
   endtask

   task automatic t_reset();
      chk(bus_cs_n && bus_wr_n && disp_cs_n, "R1", "strobes high after reset",
          {bus_cs_n, bus_wr_n, disp_cs_n}, 7);
      chk(!busy, "R1", "busy low after reset", busy, 0);
      chk(bus_addr == 4'h0 && bus_data == 8'h00, "R1", "bus zero after reset",
          {bus_addr, bus_data}, 0);
      repeat (10) @(negedge clk);
      chk(bus_cs_n && !busy, "R2", "no activity without pair_valid", {bus_cs_n, busy}, 2);
   endtask

   task automatic t_default_width();
      launch(8'hA6, 8'h3C);
      capture(60, -1, 0, 0, -1, 0, 0, -1, 2'b11);
      check_cycle(0, 27, 4'h6, 8'h3C, "R1 default width");
      chk(!bsy_a[SPAN], "R8", "busy drops at spacing end", bsy_a[SPAN], 0);
      chk(ad_a[SPAN + 5] == 4'h6 && dt_a[SPAN + 5] == 8'h3C, "R7", "bus held after cycle",
          {ad_a[SPAN + 5], dt_a[SPAN + 5]}, 12'h63C);
      chk(cs_a[SPAN + 5] && wr_a[SPAN + 5] && dcs_a[SPAN + 5], "R10", "idle strobes high",
          {cs_a[SPAN + 5], wr_a[SPAN + 5], dcs_a[SPAN + 5]}, 7);
   endtask

   task automatic t_width_codes();
      set_width(2'b00);
      launch(8'h51, 8'h11);
      capture(60, -1, 0, 0, -1, 0, 0, -1, 2'b00);
      check_cycle(0, 9, 4'h1, 8'h11, "R5 code 00");
      set_width(2'b01);
      launch(8'hF2, 8'h22);
      capture(60, -1, 0, 0, -1, 0, 0, -1, 2'b01);
      check_cycle(0, 15, 4'h2, 8'h22, "R5 code 01 R3 data/control bit");
      set_width(2'b10);
      launch(8'h0D, 8'h44);
      capture(60, -1, 0, 0, -1, 0, 0, -1, 2'b10);
      check_cycle(0, 21, 4'hD, 8'h44, "R5 code 10 R3 read bit");
   endtask

   task automatic t_width_mid_strobe();
      // Setting is 21 cycles; rewrite to 9 during the strobe.
      launch(8'h87, 8'h99);
      capture(60, -1, 0, 0, -1, 0, 0, 10, 2'b00);
      check_cycle(0, 21, 4'h7, 8'h99, "R5 mid-strobe write kept");
      launch(8'h88, 8'h9A);
      capture(60, -1, 0, 0, -1, 0, 0, -1, 2'b00);
      check_cycle(0, 9, 4'h8, 8'h9A, "R5 new width next cycle");
   endtask

   task automatic t_pending();
      set_width(2'b11);
      launch(8'h35, 8'h5A);
      capture(120, 10, 8'h4C, 8'hC3, 20, 8'h7F, 8'hFF, -1, 2'b11);
      check_cycle(0, 27, 4'h5, 8'h5A, "R9 first");
      check_cycle(SPAN, 27, 4'hC, 8'hC3, "R9 pending back-to-back");
      chk(bsy_a[SPAN - 1] && bsy_a[SPAN], "R9", "busy stays high across restart",
          {bsy_a[SPAN - 1], bsy_a[SPAN]}, 3);
      begin
         int act = 0;
         for (int k = 2 * SPAN; k < 120; k++) if (!cs_a[k] || bsy_a[k]) act++;
         chk(act == 0, "R9", "third request dropped", act, 0);
         chk(ad_a[119] == 4'hC, "R9", "bus keeps second request address", ad_a[119], 4'hC);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_width();
      t_width_codes();
      t_width_mid_strobe();
      t_pending();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule